// File: doc/BRIEF.md
# Secure Range Guard

This block sits beside a memory path and decides, for each access, whether the access may go ahead. It holds a bank of range descriptors. Each descriptor names a region of power-of-two size (at least 1 MB) by a 1 MB-granular base and a log2 size code, and gives that region one of four permissions: read-write, read-only, write-only, or no access at all. Addresses that land in no valid region take a default permission, which is kept in spare bits of descriptor slot 0.

Each access presented on the check port receives a registered response one cycle later. A denied access raises a one-cycle abort and records its address and direction in fault registers. Boot code programs the descriptors through a small register port. It then sets a sticky lock bit in a control register. From that point until the next reset, the descriptors and the lock cannot be changed.

Top module: `sec_range_guard`

## Requirements
- R1: After reset every descriptor reads as zero (invalid), the control register reads zero, and any access, read or write, at any address is allowed.
- R2: The descriptor for slot i sits at register offset 0x80 + 8*i. In a written word, bit 0 is the valid flag, bits [2:1] the permission, bits [12:8] the size code and bits [31:20] the base. Readback returns those fields and zero in every other bit, except as R3 allows.
- R3: In slot 0 only, bits [5:4] hold the default permission for unmatched addresses and bit 6 holds a stored zone-enable flag. Both read back from slot 0. In every other slot, bits [6:4] read as zero.
- R4: An address matches a valid slot when address bits [31:20] equal the base after ignoring the lowest code bits. A code of 12 or more matches every address.
- R5: A slot with bit 0 clear matches nothing, whatever its other fields hold.
- R6: When several valid slots match, the slot with the lowest index supplies the permission.
- R7: Permission codes: 0 allows reads and writes, 1 allows only reads, 2 allows only writes, 3 allows nothing.
- R8: An address that matches no valid slot takes the permission held in slot 0 bits [5:4], even when slot 0 itself is invalid.
- R9: An access sampled at a clock edge (accValid high) gives rspValid high for exactly the following cycle. rspAbort is high in that same cycle when, and only when, the access is denied.
- R10: On a denied access, faultAddr and faultWrite take the access address and direction (1 = write). Otherwise they keep their values.
- R11: Writing the control register at offset 0x00 with bit 31 set sets the lock. The control register reads back the lock in bit 31 and zero elsewhere. Writing bit 31 as zero never clears the lock.
- R12: While the lock is set, writes to every descriptor are ignored, and the lock stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | CFG_AW | Register byte offset for write and read |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for cfgAddr (combinational) |
| accValid | input | 1 | Access to check is present |
| accWrite | input | 1 | Access direction, 1 = write |
| accAddr | input | 32 | Access address |
| rspValid | output | 1 | Response for the access of the previous cycle |
| rspAbort | output | 1 | Access of the previous cycle is denied |
| faultAddr | output | 32 | Address of the last denied access |
| faultWrite | output | 1 | Direction of the last denied access |

## Verification
Some properties are checked on every cycle. A response pulse follows exactly the cycles in which an access was offered, and an abort appears only together with a response. The fault registers either capture the denied access or hold still. The lock never drops, and a locked register bank returns unchanged read data while the offset does not change. The decision itself cannot be checked that way. Whether an address matches a region under a given size code, which slot wins an overlap, what the default permission does, and how each permission code treats reads and writes are shown only by the bench scenarios. The bench compares those scenarios against its own model of the descriptor bank.

// File: rtl/srg_pkg.sv
package srg_pkg;

  localparam int ADDR_W    = 32;
  localparam int PAGE_LSB  = 20;
  localparam int BASE_W    = ADDR_W - PAGE_LSB;
  localparam int SIZE_W    = 5;
  localparam int IDX_W     = 8;

  localparam int VALID_BIT = 0;
  localparam int PERM_LSB  = 1;
  localparam int DFLT_LSB  = 4;
  localparam int ZONE_BIT  = 6;
  localparam int SIZE_LSB  = 8;
  localparam int BASE_LSB  = 20;
  localparam int LOCK_BIT  = 31;

  typedef enum logic [1:0] {
    PERM_RW   = 2'd0,
    PERM_RO   = 2'd1,
    PERM_WO   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] sizeCode;
    perm_e             perm;
    logic              valid;
  } slot_t;

  typedef struct packed {
    logic             descWe;
    logic [IDX_W-1:0] descIdx;
  } cfg_strobe_t;

  function automatic logic permits(perm_e p, logic isWrite);
    case (p)
      PERM_RW: permits = 1'b1;
      PERM_RO: permits = !isWrite;
      PERM_WO: permits = isWrite;
      default: permits = 1'b0;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] sizeMask(logic [SIZE_W-1:0] code);
    if (code >= SIZE_W'(BASE_W)) sizeMask = '0;
    else sizeMask = {BASE_W{1'b1}} << code;
  endfunction

  function automatic slot_t unpackSlot(logic [31:0] w);
    slot_t s;
    s.valid    = w[VALID_BIT];
    s.perm     = perm_e'(w[PERM_LSB +: 2]);
    s.sizeCode = w[SIZE_LSB +: SIZE_W];
    s.base     = w[BASE_LSB +: BASE_W];
    return s;
  endfunction

  function automatic logic [31:0] packSlot(slot_t s);
    logic [31:0] w;
    w = '0;
    w[VALID_BIT]           = s.valid;
    w[PERM_LSB +: 2]       = s.perm;
    w[SIZE_LSB +: SIZE_W]  = s.sizeCode;
    w[BASE_LSB +: BASE_W]  = s.base;
    return w;
  endfunction

endpackage

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       stb,
  input  logic [31:0]       cfgWdata,
  input  logic [SIDX_W-1:0] rdIdx,
  input  logic [BASE_W-1:0] accPage,
  output logic [31:0]       slotWord,
  output perm_e             hitPerm
);

  slot_t                slotArr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit;
  perm_e                dfltPermQ;
  logic                 zoneEnQ;

  // one storage register and one comparator per descriptor slot
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    slot_t q;
    logic  wrSel;
    assign wrSel = stb.descWe && (stb.descIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (wrSel) q <= unpackSlot(cfgWdata);
    end

    assign slotArr[g] = q;
    assign hit[g] = q.valid && (((accPage ^ q.base) & sizeMask(q.sizeCode)) == '0);
  end

  // unmatched-space fields live beside slot 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dfltPermQ <= PERM_RW;
      zoneEnQ   <= 1'b0;
    end else if (stb.descWe && stb.descIdx == '0) begin
      dfltPermQ <= perm_e'(cfgWdata[DFLT_LSB +: 2]);
      zoneEnQ   <= cfgWdata[ZONE_BIT];
    end
  end

  // lowest index wins: scan from the top so lower slots overwrite
  always_comb begin
    hitPerm = dfltPermQ;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) hitPerm = slotArr[i].perm;
    end
  end

  always_comb begin
    slotWord = packSlot(slotArr[rdIdx]);
    if (rdIdx == '0) begin
      slotWord[DFLT_LSB +: 2] = dfltPermQ;
      slotWord[ZONE_BIT]      = zoneEnQ;
    end
  end

endmodule

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CFG_AW    = 8,
  parameter int CTRL_OFS  = 'h00,
  parameter int SLOT_OFS  = 'h80,
  localparam int SIDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SLOT_SPAN = NUM_SLOTS * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgLockBit,
  input  logic [31:0]       slotWord,
  input  perm_e             hitPerm,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output cfg_strobe_t       stb,
  output logic [SIDX_W-1:0] rdIdx,
  output logic [31:0]       cfgRdata,
  output logic              lockedO,
  output logic              rspValid,
  output logic              rspAbort,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite
);

  logic [CFG_AW-1:0] slotRel;
  logic              slotSel;
  logic              ctrlSel;
  logic              lockQ;
  logic              deny;

  assign slotRel = cfgAddr - CFG_AW'(SLOT_OFS);
  assign slotSel = (cfgAddr >= CFG_AW'(SLOT_OFS))
                && ({1'b0, slotRel} < (CFG_AW + 1)'(SLOT_SPAN))
                && (slotRel[2:0] == 3'b000);
  assign ctrlSel = (cfgAddr == CFG_AW'(CTRL_OFS));
  assign rdIdx   = SIDX_W'(slotRel >> 3);

  assign stb.descWe  = cfgWe && slotSel && !lockQ;
  assign stb.descIdx = IDX_W'(rdIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else if (cfgWe && ctrlSel && cfgLockBit) lockQ <= 1'b1;
  end
  assign lockedO = lockQ;

  always_comb begin
    cfgRdata = '0;
    if (ctrlSel) cfgRdata[LOCK_BIT] = lockQ;
    else if (slotSel) cfgRdata = slotWord;
  end

  assign deny = !permits(hitPerm, accWrite);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspAbort   <= 1'b0;
      faultAddr  <= '0;
      faultWrite <= 1'b0;
    end else begin
      rspValid <= accValid;
      rspAbort <= accValid && deny;
      if (accValid && deny) begin
        faultAddr  <= accAddr;
        faultWrite <= accWrite;
      end
    end
  end

endmodule

// File: rtl/sec_range_guard.sv
module sec_range_guard
  import srg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CFG_AW    = 8,
  parameter int CTRL_OFS  = 'h00,
  parameter int SLOT_OFS  = 'h80,
  localparam int SIDX_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              rspValid,
  output logic              rspAbort,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite
);

  cfg_strobe_t       stb;
  logic [SIDX_W-1:0] rdIdx;
  logic [31:0]       slotWord;
  perm_e             hitPerm;
  logic              lockState;

  srg_datapath #(.NUM_SLOTS(NUM_SLOTS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgWdata (cfgWdata),
    .rdIdx    (rdIdx),
    .accPage  (accAddr[ADDR_W-1:PAGE_LSB]),
    .slotWord (slotWord),
    .hitPerm  (hitPerm)
  );

  srg_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .CFG_AW    (CFG_AW),
    .CTRL_OFS  (CTRL_OFS),
    .SLOT_OFS  (SLOT_OFS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgLockBit (cfgWdata[LOCK_BIT]),
    .slotWord   (slotWord),
    .hitPerm    (hitPerm),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .accAddr    (accAddr),
    .stb        (stb),
    .rdIdx      (rdIdx),
    .cfgRdata   (cfgRdata),
    .lockedO    (lockState),
    .rspValid   (rspValid),
    .rspAbort   (rspAbort),
    .faultAddr  (faultAddr),
    .faultWrite (faultWrite)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker
  import srg_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ADDR_W-1:0] accAddr,
  input logic              rspValid,
  input logic              rspAbort,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              faultWrite,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic [31:0]       cfgRdata,
  input logic              locked
);

  // R9
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);

  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !rspValid);

  // R9
  abort_with_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> rspValid);

  // R10
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> (faultAddr == $past(accAddr) && faultWrite == $past(accWrite)));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspAbort |-> ($stable(faultAddr) && $stable(faultWrite)));

  // R12
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R12
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(locked) && $stable(cfgAddr)) |-> $stable(cfgRdata));

endmodule

bind sec_range_guard srg_checker i_srg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .accValid   (accValid),
  .accWrite   (accWrite),
  .accAddr    (accAddr),
  .rspValid   (rspValid),
  .rspAbort   (rspAbort),
  .faultAddr  (faultAddr),
  .faultWrite (faultWrite),
  .cfgAddr    (cfgAddr),
  .cfgRdata   (cfgRdata),
  .locked     (lockState)
);

// File: tb/test_sec_range_guard.sv
`timescale 1ns/1ps
module test_sec_range_guard;

  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accAddr = '0;
  logic        rspValid;
  logic        rspAbort;
  logic [31:0] faultAddr;
  logic        faultWrite;

  always #10 clk = ~clk;

  sec_range_guard i_sec_range_guard (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .rspValid(rspValid), .rspAbort(rspAbort), .faultAddr(faultAddr), .faultWrite(faultWrite)
  );

  int          vectors = 0;
  int          errors = 0;
  bit          done = 0;
  logic [31:0] mdl [NS];
  bit          mLock;
  logic [31:0] mFaultA;
  logic        mFaultW;

  function automatic logic [31:0] maskFor(int i);
    return (i == 0) ? 32'hFFF0_1F77 : 32'hFFF0_1F07;
  endfunction

  function automatic logic [1:0] refPerm(logic [31:0] a);
    for (int i = 0; i < NS; i++) begin
      if (mdl[i][0]) begin
        int c;
        logic [11:0] m;
        c = int'(mdl[i][12:8]);
        m = (c >= 12) ? 12'h000 : (12'hFFF << c);
        if (((a[31:20] ^ mdl[i][31:20]) & m) == 12'h000) return mdl[i][2:1];
      end
    end
    return mdl[0][5:4];
  endfunction

  function automatic bit refDeny(logic [31:0] a, logic wr);
    logic [1:0] p;
    p = refPerm(a);
    return wr ? (p == 2'd1 || p == 2'd3) : (p >= 2'd2);
  endfunction

  function automatic logic [31:0] refRead(logic [7:0] a);
    if (a == 8'h00) return {mLock, 31'b0};
    if (a >= 8'h80 && a[2:0] == 3'b000) return mdl[(a - 8'h80) >> 3];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < NS; i++) mdl[i] = '0;
    mLock = 0; mFaultA = '0; mFaultW = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfgWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!mLock) begin
      if (a == 8'h00) begin
        if (d[31]) mLock = 1;
      end else if (a >= 8'h80 && a[2:0] == 3'b000) begin
        mdl[(a - 8'h80) >> 3] = d & maskFor(int'((a - 8'h80) >> 3));
      end
    end
  endtask

  task automatic cfgRd(logic [7:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    cfgAddr = a;
    #1;
    e = refRead(a);
    chk(cfgRdata === e, req, cfgRdata, e);
  endtask

  task automatic access(logic [31:0] a, logic wr, string req);
    bit d;
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr;
    d = refDeny(a, wr);
    @(negedge clk);
    accValid = 1'b0;
    chk(rspValid === 1'b1, {req, " R9 rspValid"}, 32'(rspValid), 32'd1);
    chk(rspAbort === d, req, 32'(rspAbort), 32'(d));
    if (d) begin
      mFaultA = a; mFaultW = wr;
    end
    chk(faultAddr === mFaultA && faultWrite === mFaultW, {req, " R10 fault"},
        faultAddr, mFaultA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    doReset();

    // R1: reset state
    @(negedge clk);
    chk(rspValid === 1'b0 && rspAbort === 1'b0, "R1 rsp idle", 32'(rspAbort), 32'd0);
    chk(faultAddr === 32'h0, "R1 fault clear", faultAddr, 32'h0);
    cfgRd(8'h00, "R1 ctrl");
    cfgRd(8'h80, "R1 slot0");
    cfgRd(8'hA8, "R1 slot5");
    access(32'h1234_5678, 1'b0, "R1 read open");
    access(32'hFEDC_BA98, 1'b1, "R1 write open");

    // R2 / R3: field layout and masking
    cfgWr(8'h98, 32'hFFFF_FFFF);
    cfgRd(8'h98, "R2 slot3 masked");
    cfgWr(8'h80, 32'hFFFF_FFFF);
    cfgRd(8'h80, "R3 slot0 extra bits");
    access(32'h0000_0000, 1'b0, "R4 code31 covers all");
    cfgWr(8'h80, 32'h0);
    cfgWr(8'h98, 32'h0);
    cfgRd(8'h84, "R2 gap offset");

    // R8: default permission for unmatched space
    cfgWr(8'h80, 32'h0000_0030);
    access(32'h0010_0000, 1'b0, "R8 dflt none read");
    access(32'h0010_0000, 1'b1, "R8 dflt none write");
    cfgWr(8'h80, 32'h0000_0010);
    access(32'h2000_0000, 1'b0, "R8 R7 dflt ro read");
    access(32'h2000_0000, 1'b1, "R8 R7 dflt ro write");
    cfgWr(8'h80, 32'h0000_0020);
    access(32'h2000_0000, 1'b0, "R8 R7 dflt wo read");
    access(32'h2000_0000, 1'b1, "R8 R7 dflt wo write");

    // R4 / R7: regions with defaults set to no access
    cfgWr(8'h80, 32'h0000_0030);
    cfgWr(8'h88, 32'h4000_0203);          // slot1 base 0x400, 4 MB, read-only
    access(32'h4000_0000, 1'b0, "R4 R7 ro low read");
    access(32'h403F_FFFF, 1'b0, "R4 ro top read");
    access(32'h4000_1000, 1'b1, "R7 ro write");
    access(32'h4040_0000, 1'b0, "R4 past end");
    access(32'h3FFF_FFFF, 1'b0, "R4 below base");
    cfgWr(8'h90, 32'h8050_0305);          // slot2 base 0x805, code 3, write-only
    access(32'h8000_0000, 1'b1, "R4 R7 wo write low bits ignored");
    access(32'h8000_0000, 1'b0, "R7 wo read");
    access(32'h807F_FFFF, 1'b1, "R4 wo top");
    access(32'h8080_0000, 1'b1, "R4 wo past end");
    cfgWr(8'hA0, 32'h0000_0F01);          // slot4 code 15, read-write
    access(32'h1234_5678, 1'b1, "R4 big code");
    cfgWr(8'hA0, 32'h0000_0F00);
    access(32'h1234_5678, 1'b1, "R5 invalid slot");

    // R6: overlap, lower index wins
    cfgWr(8'hA8, 32'h4000_0001);          // slot5 1 MB read-write in slot1 region
    access(32'h4000_0000, 1'b1, "R6 lower slot wins");
    cfgWr(8'h88, 32'h0);
    access(32'h4000_0000, 1'b1, "R6 slot5 after slot1 cleared");

    // R9: single-cycle response
    access(32'h4000_0000, 1'b0, "R9 pulse");
    @(negedge clk);
    chk(rspValid === 1'b0 && rspAbort === 1'b0, "R9 one cycle", 32'(rspValid), 32'd0);

    // random programming and accesses
    for (int n = 0; n < 400; n++) begin
      int unsigned k;
      logic [31:0] d;
      k = $urandom % NS;
      if (($urandom % 4) == 0) begin
        d = $urandom;
        d[12] = 1'b0;
        cfgWr(8'h80 + 8'(k * 8), d);
        cfgRd(8'h80 + 8'(k * 8), "R2 R3 random readback");
      end else begin
        logic [31:0] a;
        a = {mdl[k][31:20] ^ 12'($urandom % 4), 20'($urandom)};
        access(a, 1'($urandom), "R4 R6 R7 random access");
      end
    end

    // R11 / R12: lock
    cfgWr(8'h80, 32'h0000_0030);
    cfgWr(8'h88, 32'h4000_0203);
    cfgWr(8'h00, 32'h7FFF_FFFF);
    cfgRd(8'h00, "R11 no lock without bit31");
    cfgWr(8'h00, 32'h8000_0000);
    cfgRd(8'h00, "R11 lock set");
    cfgWr(8'h88, 32'h0000_0000);
    cfgRd(8'h88, "R12 slot1 frozen");
    access(32'h4000_0000, 1'b0, "R12 region still active");
    cfgWr(8'h80, 32'h0000_0000);
    access(32'h0500_0000, 1'b1, "R12 dflt frozen");
    cfgWr(8'h00, 32'h0000_0000);
    cfgRd(8'h00, "R11 R12 lock sticky");

    doReset();
    cfgRd(8'h00, "R12 reset clears lock");
    cfgWr(8'h88, 32'h4000_0203);
    cfgRd(8'h88, "R12 writable after reset");

    finishRun();
  end

endmodule